// File: doc/BRIEF.md
# CPU power mode controller

This block holds a 16-bit mode control register on a simple register bus and turns its contents into the clock and power controls of a processor core. A single 4-bit mode field selects one of five operating states. In the fast run state the PLL and the fast clock are active. In the slow run state the PLL is off and the slow clock is selected. Each of the two halt states gates only the CPU clock and keeps the clocks of the run state it was entered from. In the stop state the PLL, the CPU clock and the system clock are all switched off. The block refuses reserved encodings and illegal transitions and flags each refusal for one cycle. A wake pulse brings it back from a halt or stop state to the run state that preceded it.

The top bit of the register is an active-low watchdog enable. While it is set, the external watchdog counter is disabled. Writing it from set to clear emits a one-cycle clear strobe, so that the counter restarts from zero. A read-only status bit shows whether the slow clock source is currently selected. The PLL, the oscillators, the watchdog counter and the clock dividers are outside this block. It only drives their enables and selects.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the register reads 0x8000. The block is in fast run with pll_en_o=1, clk_slow_sel_o=0, cpu_clk_en_o=1 and sys_clk_en_o=1. The outputs wdt_en_o, wdt_clr_o and mode_err_o are all 0.
- R2: The register sits at address 0x00FC00. Bit 15 reads the watchdog disable bit, bit 14 reads the slow-clock status (1 = slow selected), and bits 3:0 read the mode field {STOP,HALT,OSC1,OSC0}. Bits 13:4 always read 0. At any other address bus_rdata is 0, and writes there change nothing.
- R3: Mode field 0000 is fast run: the PLL is on, the fast clock is selected, and the CPU and system clocks are enabled.
- R4: Mode field 0011 is slow run: the PLL is off, the slow clock is selected, the CPU and system clocks are enabled, and the status bit reads 1.
- R5: Mode field 0100 is fast halt and is accepted only from fast run. The CPU clock is gated, and the PLL, the fast select and the system clock stay on.
- R6: Mode field 0111 is slow halt and is accepted only from slow run. The CPU clock is gated, the PLL stays off, the slow clock stays selected, and the system clock stays on.
- R7: Mode field 10xx is stop and is accepted from either run state. The PLL, the CPU clock and the system clock are all off. The clock select and the status bit keep the value of the run state that preceded the stop, and the field reads back as written.
- R8: A write at the register address whose mode field is reserved (0001, 0010, 0101, 0110 or 11xx) leaves the mode unchanged. mode_err_o is then 1 in the following cycle only.
- R9: A write of a halt encoding that does not match the current run state is refused. So is any write that changes the mode field while the block is halted or stopped. Each refusal leaves the mode unchanged and raises mode_err_o for one cycle.
- R10: A wake_i pulse in a halt state clears the HALT bit, so the block returns to the run state the halt was entered from.
- R11: A wake_i pulse in stop restores the run state that was active before the stop. The field then reads 0000 or 0011.
- R12: wdt_en_o is the inverse of bit 15. A write that changes bit 15 from 1 to 0 makes wdt_clr_o 1 in the next cycle only. A write of 0 while bit 15 is already 0 gives no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 16 | Register bus write data |
| bus_rdata | output | 16 | Register bus read data (combinational on address) |
| wake_i | input | 1 | Wake pulse from the interrupt logic |
| pll_en_o | output | 1 | PLL enable |
| clk_slow_sel_o | output | 1 | Clock source select, 1 = slow |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| wdt_en_o | output | 1 | Watchdog counter enable |
| wdt_clr_o | output | 1 | One-cycle watchdog clear strobe |
| mode_err_o | output | 1 | One-cycle flag for a refused mode write |

## Verification
The hardest case to reach from the ports is a stop entered from slow run, followed by a wake. The stop encoding carries OSC bits that differ from those of the run state before it. The only evidence of the run state remembered across the stop is therefore the clock select and the status bit during the stop, and the field that reads back after the wake. The stimulus first moves the block to slow run and writes stop with OSC=01. It checks the select during the stop, then pulses wake_i and expects 0011. The same sequence is repeated from fast run. Refused writes are issued while the block is halted and while it is in the wrong run state, and the read-back shows that the mode held.

// File: rtl/pmc_pkg.sv
// Package: shared types and mode-field decoding for the power mode controller.
// Assumes the mode field is {STOP, HALT, OSC1, OSC0}.
package pmc_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [2:0] {
        PM_RUN_FAST  = 3'd0,
        PM_RUN_SLOW  = 3'd1,
        PM_HALT_FAST = 3'd2,
        PM_HALT_SLOW = 3'd3,
        PM_STOP      = 3'd4,
        PM_RESERVED  = 3'd7
    } pm_mode_e;

    typedef struct packed {
        logic pll_en;
        logic slow_sel;
        logic cpu_en;
        logic sys_en;
    } clk_ctl_t;

    // Map a mode field onto its operating state; unlisted codes are reserved.
    function automatic pm_mode_e field_to_mode(input logic [FIELD_W-1:0] f);
        pm_mode_e m;
        case (f)
            4'b0000: m = PM_RUN_FAST;
            4'b0011: m = PM_RUN_SLOW;
            4'b0100: m = PM_HALT_FAST;
            4'b0111: m = PM_HALT_SLOW;
            4'b1000, 4'b1001, 4'b1010, 4'b1011: m = PM_STOP;
            default: m = PM_RESERVED;
        endcase
        return m;
    endfunction

    // True when the state runs the CPU.
    function automatic logic is_run(input pm_mode_e m);
        return (m == PM_RUN_FAST) || (m == PM_RUN_SLOW);
    endfunction

endpackage

// File: rtl/pmc_bus_regs.sv
// Module: register bus decode and watchdog control bit.
// Holds the active-low watchdog enable, generates the clear strobe, forwards
// mode-field writes to the mode sequencer and assembles the read word.
// Assumes a single-cycle write with address and data valid at the clock edge.
module pmc_bus_regs #(
    parameter int              ADDR_W   = 24,
    parameter int              DATA_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 24'h00FC00,
    parameter int              WD_BIT   = 15,
    parameter int              OSC_BIT  = 14,
    parameter int              FIELD_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [FIELD_W-1:0]  mode_field,
    input  logic                osc_slow,
    output logic                fld_wr,
    output logic [FIELD_W-1:0]  fld_wdata,
    output logic                wdt_en,
    output logic                wdt_clr
);

    localparam int GAP_LO = FIELD_W;
    localparam int GAP_HI = OSC_BIT - 1;

    logic hit;
    logic wr_hit;
    logic nwden_q;
    logic clr_q;
    logic [DATA_W-1:0] rd_word;
    logic unused_wbits;

    // Address match for the single register.
    assign hit    = (bus_addr == REG_ADDR);
    assign wr_hit = hit && bus_we;

    assign fld_wr    = wr_hit;
    assign fld_wdata = bus_wdata[FIELD_W-1:0];
    assign unused_wbits = ^bus_wdata[OSC_BIT:GAP_LO];

    // Watchdog disable bit and its one-cycle clear strobe on a 1-to-0 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nwden_q <= 1'b1;
            clr_q   <= 1'b0;
        end else begin
            clr_q <= wr_hit && nwden_q && !bus_wdata[WD_BIT];
            if (wr_hit) begin
                nwden_q <= bus_wdata[WD_BIT];
            end
        end
    end

    assign wdt_en  = !nwden_q;
    assign wdt_clr = clr_q;

    // Read word assembly; unused bits read zero.
    always_comb begin
        rd_word                    = '0;
        rd_word[WD_BIT]            = nwden_q;
        rd_word[OSC_BIT]           = osc_slow;
        rd_word[FIELD_W-1:0]       = mode_field;
        rd_word[GAP_HI:GAP_LO]     = '0;
    end

    assign bus_rdata = hit ? rd_word : '0;

endmodule

// File: rtl/pmc_mode_seq.sv
// Module: mode sequencer.
// Accepts legal mode-field writes, refuses reserved codes and illegal
// transitions with a one-cycle error, and handles wake from halt and stop.
// Assumes wake_i is synchronous to clk; wake wins over a same-cycle write.
module pmc_mode_seq
    import pmc_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fld_wr,
    input  logic [FIELD_W-1:0] fld_wdata,
    input  logic               wake_i,
    output logic [FIELD_W-1:0] mode_field,
    output pm_mode_e           mode,
    output logic               stop_slow,
    output logic               mode_err
);

    localparam logic [FIELD_W-1:0] F_RUN_FAST = 4'b0000;
    localparam logic [FIELD_W-1:0] F_RUN_SLOW = 4'b0011;

    logic [FIELD_W-1:0] field_q;
    logic               stop_slow_q;
    logic               err_q;
    pm_mode_e           tgt;
    logic               cur_run;
    logic               tgt_ok;
    logic               accept;
    logic               wake_act;
    logic [FIELD_W-1:0] wake_field;

    assign mode    = field_to_mode(field_q);
    assign tgt     = field_to_mode(fld_wdata);
    assign cur_run = is_run(mode);

    // Legality of a requested target from the current state.
    always_comb begin
        case (tgt)
            PM_RUN_FAST, PM_RUN_SLOW, PM_STOP: tgt_ok = cur_run;
            PM_HALT_FAST:                      tgt_ok = (mode == PM_RUN_FAST);
            PM_HALT_SLOW:                      tgt_ok = (mode == PM_RUN_SLOW);
            default:                           tgt_ok = 1'b0;
        endcase
    end

    assign accept = (tgt != PM_RESERVED) && (tgt_ok || (fld_wdata == field_q));

    // Wake acts only outside the run states.
    assign wake_act = wake_i && !cur_run;

    // Run state to return to on wake.
    always_comb begin
        case (mode)
            PM_HALT_SLOW: wake_field = F_RUN_SLOW;
            PM_STOP:      wake_field = stop_slow_q ? F_RUN_SLOW : F_RUN_FAST;
            default:      wake_field = F_RUN_FAST;
        endcase
    end

    // Mode state, remembered run state across stop, and refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q     <= F_RUN_FAST;
            stop_slow_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            err_q <= fld_wr && !wake_act && !accept;
            if (wake_act) begin
                field_q <= wake_field;
            end else if (fld_wr && accept) begin
                field_q <= fld_wdata;
                if ((tgt == PM_STOP) && cur_run) begin
                    stop_slow_q <= (mode == PM_RUN_SLOW);
                end
            end
        end
    end

    assign mode_field = field_q;
    assign stop_slow  = stop_slow_q;
    assign mode_err   = err_q;

endmodule

// File: rtl/pmc_clk_dec.sv
// Module: clock control decoder.
// Turns the operating state into PLL, source select and clock enables.
// Assumes the stop state takes its source select from the remembered run state.
module pmc_clk_dec
    import pmc_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     stop_slow,
    output clk_ctl_t ctl
);

    // State-to-control table.
    always_comb begin
        case (mode)
            PM_RUN_FAST:  ctl = '{pll_en: 1'b1, slow_sel: 1'b0, cpu_en: 1'b1, sys_en: 1'b1};
            PM_RUN_SLOW:  ctl = '{pll_en: 1'b0, slow_sel: 1'b1, cpu_en: 1'b1, sys_en: 1'b1};
            PM_HALT_FAST: ctl = '{pll_en: 1'b1, slow_sel: 1'b0, cpu_en: 1'b0, sys_en: 1'b1};
            PM_HALT_SLOW: ctl = '{pll_en: 1'b0, slow_sel: 1'b1, cpu_en: 1'b0, sys_en: 1'b1};
            PM_STOP:      ctl = '{pll_en: 1'b0, slow_sel: stop_slow, cpu_en: 1'b0, sys_en: 1'b0};
            default:      ctl = '{pll_en: 1'b1, slow_sel: 1'b0, cpu_en: 1'b1, sys_en: 1'b1};
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctl.sv
// Module: CPU power mode controller top.
// Connects the bus register, mode sequencer and clock decoder.
// Assumes one clock domain and a synchronous active-low reset.
module pwr_mode_ctl
    import pmc_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 24'h00FC00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake_i,
    output logic              pll_en_o,
    output logic              clk_slow_sel_o,
    output logic              cpu_clk_en_o,
    output logic              sys_clk_en_o,
    output logic              wdt_en_o,
    output logic              wdt_clr_o,
    output logic              mode_err_o
);

    localparam int WD_BIT  = DATA_W - 1;
    localparam int OSC_BIT = DATA_W - 2;

    logic [FIELD_W-1:0] fld_wdata;
    logic [FIELD_W-1:0] mode_field;
    logic               fld_wr;
    logic               stop_slow;
    pm_mode_e           mode;
    clk_ctl_t           ctl;

    pmc_bus_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .REG_ADDR(REG_ADDR),
        .WD_BIT  (WD_BIT),
        .OSC_BIT (OSC_BIT),
        .FIELD_W (FIELD_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mode_field(mode_field),
        .osc_slow  (ctl.slow_sel),
        .fld_wr    (fld_wr),
        .fld_wdata (fld_wdata),
        .wdt_en    (wdt_en_o),
        .wdt_clr   (wdt_clr_o)
    );

    pmc_mode_seq #(
        .FIELD_W(FIELD_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fld_wr    (fld_wr),
        .fld_wdata (fld_wdata),
        .wake_i    (wake_i),
        .mode_field(mode_field),
        .mode      (mode),
        .stop_slow (stop_slow),
        .mode_err  (mode_err_o)
    );

    pmc_clk_dec u_dec (
        .mode     (mode),
        .stop_slow(stop_slow),
        .ctl      (ctl)
    );

    assign pll_en_o       = ctl.pll_en;
    assign clk_slow_sel_o = ctl.slow_sel;
    assign cpu_clk_en_o   = ctl.cpu_en;
    assign sys_clk_en_o   = ctl.sys_en;

endmodule

// File: rtl/pmc_sva.sv
// Module: assertion checker for the power mode controller, bound to the top.
// Assumes reset is held for at least one clock edge before release.
module pmc_sva #(
    parameter int                ADDR_W   = 24,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 24'h00FC00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [3:0]        mode_field,
    input logic              pll_en_o,
    input logic              clk_slow_sel_o,
    input logic              cpu_clk_en_o,
    input logic              sys_clk_en_o,
    input logic              wdt_en_o,
    input logic              wdt_clr_o,
    input logic              mode_err_o
);

    AST_PLL_NOT_ON_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en_o |-> !clk_slow_sel_o); // R4

    AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_clk_en_o |-> (!cpu_clk_en_o && !pll_en_o)); // R7

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> $past(bus_we)); // R8

    AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> (mode_field == $past(mode_field))); // R9

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |=> !wdt_clr_o); // R12

    AST_CLR_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |-> wdt_en_o); // R12

    AST_STATUS_MATCHES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_ADDR) |-> (bus_rdata[DATA_W-2] == clk_slow_sel_o)); // R2

    AST_HALT_KEEPS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en_o && sys_clk_en_o && $past(cpu_clk_en_o)) |-> $stable(clk_slow_sel_o)); // R5

endmodule

bind pwr_mode_ctl pmc_sva #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_rdata     (bus_rdata),
    .mode_field    (mode_field),
    .pll_en_o      (pll_en_o),
    .clk_slow_sel_o(clk_slow_sel_o),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .sys_clk_en_o  (sys_clk_en_o),
    .wdt_en_o      (wdt_en_o),
    .wdt_clr_o     (wdt_clr_o),
    .mode_err_o    (mode_err_o)
);

// File: tb/pwr_mode_ctl_tb.sv
`timescale 1ns/1ps
// Bench: the driver pushes expected snapshots, the monitor pops and compares.
// Snapshot = {rdata[15:0], pll, slow_sel, cpu_en, sys_en, wdt_en, wdt_clr, err}.
module pwr_mode_ctl_tb;

    localparam logic [23:0] RA = 24'h00FC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = RA;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wake_i = 1'b0;
    logic        pll_en_o, clk_slow_sel_o, cpu_clk_en_o, sys_clk_en_o;
    logic        wdt_en_o, wdt_clr_o, mode_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    string       q_req[$];
    logic [22:0] q_val[$];

    always #2 clk = ~clk;

    pwr_mode_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_i(wake_i),
        .pll_en_o(pll_en_o), .clk_slow_sel_o(clk_slow_sel_o),
        .cpu_clk_en_o(cpu_clk_en_o), .sys_clk_en_o(sys_clk_en_o),
        .wdt_en_o(wdt_en_o), .wdt_clr_o(wdt_clr_o), .mode_err_o(mode_err_o)
    );

    task automatic expect_now(input string req, input logic [15:0] rd, input logic [6:0] o);
        q_req.push_back(req);
        q_val.push_back({rd, o});
    endtask

    task automatic wr(input logic [23:0] a, input logic [15:0] d,
                      input string req, input logic [15:0] rd, input logic [6:0] o);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_addr = RA; bus_we = 1'b0;
        expect_now(req, rd, o);
    endtask

    task automatic wake(input string req, input logic [15:0] rd, input logic [6:0] o);
        @(posedge clk); #1;
        wake_i = 1'b1;
        @(posedge clk); #1;
        wake_i = 1'b0;
        expect_now(req, rd, o);
    endtask

    task automatic idle(input logic [23:0] a, input string req,
                        input logic [15:0] rd, input logic [6:0] o);
        @(posedge clk); #1;
        bus_addr = a;
        expect_now(req, rd, o);
    endtask

    // Monitor: compare one expected snapshot per falling edge.
    always @(negedge clk) begin
        if (q_val.size() > 0) begin
            string       r;
            logic [22:0] e, a;
            r = q_req.pop_front();
            e = q_val.pop_front();
            a = {bus_rdata, pll_en_o, clk_slow_sel_o, cpu_clk_en_o, sys_clk_en_o,
                 wdt_en_o, wdt_clr_o, mode_err_o};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual rd=%h ctl=%b expected rd=%h ctl=%b",
                         r, a[22:7], a[6:0], e[22:7], e[6:0]);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(RA, "R1 reset", 16'h8000, 7'b1011000);
        // slow run, then wrong halt, then matching halt and wake
        wr(RA, 16'h8003, "R4 slow run", 16'hC003, 7'b0111000);
        wr(RA, 16'h8004, "R9 fast halt from slow", 16'hC003, 7'b0111001);
        idle(RA, "R8 err one cycle", 16'hC003, 7'b0111000);
        wr(RA, 16'h8007, "R6 slow halt", 16'hC007, 7'b0101000);
        wake("R10 wake slow halt", 16'hC003, 7'b0111000);
        // fast run, fast halt, refused write while halted, wake
        wr(RA, 16'h8000, "R3 fast run", 16'h8000, 7'b1011000);
        wr(RA, 16'h8004, "R5 fast halt", 16'h8004, 7'b1001000);
        wr(RA, 16'h8000, "R9 write while halted", 16'h8004, 7'b1001001);
        wake("R10 wake fast halt", 16'h8000, 7'b1011000);
        // reserved encodings
        wr(RA, 16'h8005, "R8 reserved 0101", 16'h8000, 7'b1011001);
        wr(RA, 16'h800C, "R8 reserved 1100", 16'h8000, 7'b1011001);
        wr(RA, 16'h8001, "R8 reserved 0001", 16'h8000, 7'b1011001);
        // stop from slow with different OSC bits, then wake
        wr(RA, 16'h8003, "R4 slow run again", 16'hC003, 7'b0111000);
        wr(RA, 16'h8009, "R7 stop from slow", 16'hC009, 7'b0100000);
        wr(RA, 16'h8000, "R9 write while stopped", 16'hC009, 7'b0100001);
        wake("R11 wake stop to slow", 16'hC003, 7'b0111000);
        // stop from fast, then wake
        wr(RA, 16'h8000, "R3 fast run again", 16'h8000, 7'b1011000);
        wr(RA, 16'h800B, "R7 stop from fast", 16'h800B, 7'b0000000);
        wake("R11 wake stop to fast", 16'h8000, 7'b1011000);
        // watchdog bit
        wr(RA, 16'h0000, "R12 clear strobe", 16'h0000, 7'b1011110);
        idle(RA, "R12 strobe one cycle", 16'h0000, 7'b1011100);
        wr(RA, 16'h0000, "R12 no strobe 0 to 0", 16'h0000, 7'b1011100);
        wr(RA, 16'h8000, "R12 disable", 16'h8000, 7'b1011000);
        wr(RA, 16'h0000, "R12 strobe again", 16'h0000, 7'b1011110);
        // read format and other addresses
        wr(RA, 16'hFFF3, "R2 gap bits read zero", 16'hC003, 7'b0111000);
        wr(24'h00FC02, 16'h0000, "R2 write elsewhere ignored", 16'hC003, 7'b0111000);
        idle(24'h00FC02, "R2 read elsewhere zero", 16'h0000, 7'b0111000);
        idle(RA, "R2 read back", 16'hC003, 7'b0111000);
        wait (q_val.size() == 0);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule